// File: doc/BRIEF.md
# Bus-Mapped Eight-Channel SAR Converter Controller

This block connects an 8-bit successive-approximation converter to a processor bus that has separate active-low read and write strobes. It answers at one bus address. A write to that address picks one of eight analog inputs. A read from it puts the last finished conversion result on the bus, with an output-enable flag that marks when the bus is driven.

Inside, a sequencer builds each result one bit per clock, starting from the most significant bit. It presents a trial code to the external ladder and reads back one comparator bit. When a conversion ends, the end flag restarts the sequencer, so it converts without stopping. Reset forces the first start, so no processor action is needed. The analog multiplexer, the ladder and the comparator sit outside the block. The block drives the channel-select and ladder-code outputs and takes in the comparator bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Writes decode only at address `BASE_ADDR` (default 16'h1014). A write to any other address leaves `chan_sel_o` unchanged.
- R2: The channel code is taken from write data bits [6:4], with bit 4 as the least significant bit. Data bits 7 and 3:0 are ignored.
- R3: The channel code is captured when the write strobe `bus_wr_ni` returns high, not while it is held low. A strobe held low for longer than several conversions does not change `chan_sel_o`.
- R4: `bus_oe_o` is high only during a read (`bus_rd_ni` low) at `BASE_ADDR`. It stays low during writes, during reads at other addresses and when the bus is idle.
- R5: The sequencer tests bits from MSB to LSB, one per clock. The first trial code after `eoc_o` is 8'h80. Each later trial keeps the earlier bits whose comparator sample was 1 (input ≥ code) and sets the next lower bit.
- R6: `eoc_o` is high for exactly one cycle in every 9 cycles. That is 8 bit-test cycles plus one start cycle, and the next conversion starts by itself.
- R7: After reset is released, `eoc_o` is high in the first cycle (forced start) and `chan_sel_o` is 0.
- R8: `bus_data_o` changes only on the clock edge that ends an `eoc_o` cycle. It reads 8'h00 until the first conversion completes, so reads within one period return the same whole value.
- R9: `chan_sel_o` changes only on the clock edge that ends an `eoc_o` cycle. A new channel takes effect from the next conversion start.
- R10: Once a channel has been written, a read issued 24 cycles later returns the converted value of that channel's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Decoded bus address |
| bus_wr_ni | input | 1 | Write strobe, active low |
| bus_rd_ni | input | 1 | Read strobe, active low |
| bus_data_i | input | 8 | Write data |
| bus_data_o | output | 8 | Held conversion result |
| bus_oe_o | output | 1 | High when `bus_data_o` should drive the bus |
| chan_sel_o | output | 3 | Analog multiplexer select |
| dac_code_o | output | 8 | Ladder trial code |
| cmp_i | input | 1 | Comparator: 1 when input ≥ ladder code |
| eoc_o | output | 1 | End of conversion, doubling as the start pulse |

## Verification
The assertions check four rules on every cycle: the 9-cycle rhythm of the end flag, the 8'h80 first trial after each start, that the channel select and the result output change only after an end-of-conversion cycle, and that the output enable never rises without a read strobe. Only the bench scenarios can show the rest. These are that the captured channel comes from the right data bits at the right strobe edge, that other addresses are ignored, and that the full trial sequence and the final value match each channel's modelled input, including the all-zero and all-one extremes.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned RES_W    = 8;
  localparam int unsigned CH_W     = 3;
  localparam int unsigned CH_LSB   = 4;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PERIOD   = RES_W + 1;
  localparam int unsigned IDX_W    = $clog2(RES_W);
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CH_W      = 3,
  parameter int unsigned CH_LSB    = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [CH_W-1:0]   chan_req_o,
  output logic              oe_o
);
  logic            hit;
  logic            ale_n;
  logic            ale_q;
  logic [CH_W-1:0] pend_q;

  assign hit   = (addr_i == BASE_ADDR);
  assign ale_n = ~(hit & ~wr_ni);
  assign oe_o  = hit & ~rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q      <= 1'b1;
      pend_q     <= '0;
      chan_req_o <= '0;
    end else begin
      ale_q <= ale_n;
      if (!ale_n) pend_q <= data_i[CH_LSB +: CH_W];
      // commit on low-to-high of latch enable
      if (ale_n && !ale_q) chan_req_o <= pend_q;
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int unsigned RES_W = 8,
  parameter int unsigned CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic [CH_W-1:0]  chan_req_i,
  output logic [CH_W-1:0]  chan_sel_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

  logic             st_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] trial;

  assign trial      = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
  assign dac_code_o = st_q ? sar_q : (sar_q | trial);
  assign eoc_o      = st_q;

  // st_q high = end flag looped back as start; reset forces it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= 1'b1;
      idx_q      <= IDX_TOP;
      sar_q      <= '0;
      result_o   <= '0;
      chan_sel_o <= '0;
    end else if (st_q) begin
      result_o   <= sar_q;
      sar_q      <= '0;
      idx_q      <= IDX_TOP;
      chan_sel_o <= chan_req_i;
      st_q       <= 1'b0;
    end else begin
      sar_q[idx_q] <= cmp_i;
      if (idx_q == '0) st_q  <= 1'b1;
      else             idx_q <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_ni,
  input  logic              bus_rd_ni,
  input  logic [RES_W-1:0]  bus_data_i,
  output logic [RES_W-1:0]  bus_data_o,
  output logic              bus_oe_o,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic [RES_W-1:0]  dac_code_o,
  input  logic              cmp_i,
  output logic              eoc_o
);
  logic [CH_W-1:0] chan_req;

  adc_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(RES_W), .CH_W(CH_W), .CH_LSB(CH_LSB),
    .BASE_ADDR(BASE_ADDR)
  ) i_dec (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wr_ni(bus_wr_ni), .rd_ni(bus_rd_ni),
    .data_i(bus_data_i), .chan_req_o(chan_req), .oe_o(bus_oe_o)
  );

  adc_sar_seq #(.RES_W(RES_W), .CH_W(CH_W)) i_seq (
    .clk_i, .rst_ni, .cmp_i,
    .chan_req_i(chan_req), .chan_sel_o, .dac_code_o,
    .result_o(bus_data_o), .eoc_o
  );
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import sar_adc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eoc_i,
  input logic             bus_rd_ni,
  input logic             oe_i,
  input logic [CH_W-1:0]  chan_sel_i,
  input logic [RES_W-1:0] dac_code_i,
  input logic [RES_W-1:0] data_i
);
  logic [$clog2(PERIOD)-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= $bits(cnt_q)'(PERIOD - 1);
    else if (eoc_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R6
  eoc_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i == (cnt_q == $bits(cnt_q)'(PERIOD - 1)));

  // R6
  eoc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> !eoc_i);

  // R5
  first_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> dac_code_i == {1'b1, {(RES_W-1){1'b0}}});

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_i) |-> $past(eoc_i));

  // R9
  chan_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_sel_i) |-> $past(eoc_i));

  // R4
  oe_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_ni |-> !oe_i);
endmodule

bind sar_adc_ctrl adc_ctrl_chk i_chk (
  .clk_i, .rst_ni, .eoc_i(eoc_o), .bus_rd_ni, .oe_i(bus_oe_o),
  .chan_sel_i(chan_sel_o), .dac_code_i(dac_code_o), .data_i(bus_data_o)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam logic [15:0] BASE = 16'h1014;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_wr_ni = 1'b1;
  logic        bus_rd_ni = 1'b1;
  logic [7:0]  bus_data_i = '0;
  logic [7:0]  bus_data_o;
  logic        bus_oe_o;
  logic [2:0]  chan_sel_o;
  logic [7:0]  dac_code_o;
  logic        cmp_i;
  logic        eoc_o;

  logic [7:0] ana [8];
  int checks = 0;
  int fails  = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  assign cmp_i = (ana[chan_sel_o] >= dac_code_o);

  sar_adc_ctrl i_sar_adc_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int low_cycles);
    bus_addr_i = a; bus_data_i = d; bus_wr_ni = 1'b0;
    tick(low_cycles);
    bus_wr_ni = 1'b1;
    tick();
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] expv, input string req);
    if (a == BASE) exp_q.push_back('{expv, req});
    bus_addr_i = a; bus_rd_ni = 1'b0;
    tick();
    bus_rd_ni = 1'b1;
  endtask

  task automatic wait_eoc();
    do @(negedge clk_i); while (!eoc_o);
  endtask

  // monitor: every enabled read pops one expected item
  always @(negedge clk_i) begin
    if (rst_ni && bus_oe_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output enable", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(bus_data_o == e.val, e.req, bus_data_o, e.val);
      end
    end
  end

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ana[0] = 8'h00; ana[1] = 8'hFF; ana[2] = 8'h5A; ana[3] = 8'hA5;
    ana[4] = 8'h01; ana[5] = 8'h80; ana[6] = 8'h7F; ana[7] = 8'h3C;
    tick(5);
    rst_ni = 1'b1;

    // R7: forced start after reset
    @(negedge clk_i);
    chk(eoc_o == 1'b1, "R7 eoc after reset", eoc_o, 1);
    chk(chan_sel_o == 3'd0, "R7 channel after reset", chan_sel_o, 0);
    chk(bus_oe_o == 1'b0, "R4 idle oe", bus_oe_o, 0);
    tick();
    bus_read(BASE, 8'h00, "R8 result before first conversion");

    // R2: channel 2 with unrelated data bits set
    bus_write(BASE, 8'hAF, 2);
    tick(24);
    chk(chan_sel_o == 3'd2, "R2 channel from bits 6:4", chan_sel_o, 2);

    // R5: trial sequence for input 0x5A
    wait_eoc();
    for (int s = 0; s < 8; s++) begin
      int e;
      @(negedge clk_i);
      e = (int'(ana[2]) & ((255 << (8 - s)) & 255)) | (1 << (7 - s));
      chk(dac_code_o == e[7:0], "R5 trial code", dac_code_o, e);
    end
    tick();
    bus_read(BASE, ana[2], "R10 channel 2 value");

    // R1: write elsewhere ignored
    bus_write(BASE + 16'h0001, 8'h70, 2);
    tick(24);
    chk(chan_sel_o == 3'd2, "R1 other address ignored", chan_sel_o, 2);

    // R3: long strobe, commit only on release
    bus_addr_i = BASE; bus_data_i = 8'h50; bus_wr_ni = 1'b0;
    tick(30);
    chk(chan_sel_o == 3'd2, "R3 no capture while strobe low", chan_sel_o, 2);
    chk(bus_oe_o == 1'b0, "R4 oe low during write", bus_oe_o, 0);
    bus_wr_ni = 1'b1;
    tick(24);
    chk(chan_sel_o == 3'd5, "R3 capture at strobe release", chan_sel_o, 5);
    bus_read(BASE, ana[5], "R10 channel 5 value");

    // R4: read at wrong address
    bus_addr_i = BASE ^ 16'h0100; bus_rd_ni = 1'b0;
    @(negedge clk_i);
    chk(bus_oe_o == 1'b0, "R4 oe at other address", bus_oe_o, 0);
    tick();
    bus_rd_ni = 1'b1;

    // R8: result steady within one period
    wait_eoc();
    @(negedge clk_i);
    begin
      logic [7:0] first;
      first = bus_data_o;
      for (int k = 0; k < 7; k++) begin
        @(negedge clk_i);
        chk(bus_data_o == first, "R8 result stable", bus_data_o, first);
      end
    end

    // R6: period
    wait_eoc();
    begin
      int n = 0;
      do begin @(negedge clk_i); n++; end while (!eoc_o);
      chk(n == 9, "R6 conversion period", n, 9);
    end

    // R9, R10: every channel
    for (int c = 0; c < 8; c++) begin
      tick();
      bus_write(BASE, {1'b0, 3'(c), 4'hF}, 1);
      tick(24);
      chk(chan_sel_o == 3'(c), "R9 channel applied", chan_sel_o, c);
      bus_read(BASE, ana[c], "R10 per-channel value");
      bus_read(BASE, ana[c], "R8 repeat read");
    end

    tick(4);
    chk(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule